// File: doc/BRIEF.md
# Disk Command-Chain Host Register Controller

This block is the host-facing front end of a disk controller that executes command chains held in system memory. It holds the word-wide register file the host CPU reaches through chip select and three address lines. The registers are the command/status word, the mode word, a 32-bit chain pointer, a 32-bit result-area pointer and a 16-bit result-area count. It also holds the top-level state machine, whose states are initialising, idle, running a fresh chain, and running a resumed chain.

The chain-execution engine sits outside the block. It sees two outputs, one that tells it to run and one that says whether the run is a resume. It reports back through single-cycle strobes: parameter block finished, end of chain, error stop, wait stop, result block written, and memory timeout with a 2-bit kind. From these the controller decides when to return to idle, and which fault code to report. It raises the controller-fault flag, counts down the result area, and drives the interrupt line. A host command is accepted only after a fixed latency of `CMD_LAT` clocks. While the controller is initialising, accesses are stalled through the ready output.

Top module: `dkc_host_ctrl`

## Requirements
- R1: With `cs_n` low, `addr` selects a 16-bit word as follows. 0 is command/status, 1 is mode, 2 and 3 are the chain pointer low and high words, 4 and 5 are the result pointer low and high words, 6 is the result count, and 7 reads as zero. With `cs_n` high, nothing is written and `rdata` is zero.
- R2: After a hardware reset or an accepted reset command, the block spends `RST_CYC` clocks initialising, with mode and command field cleared. It then enters idle with the fault flag set, fault code 4'hF and command field 00.
- R3: The status word is {fault flag [15], busy [14], resumed [13], 0 [12], fault code [11:8], 0 [7:2], command [1:0]}. A write to address 0 affects only bits [1:0]. The command codes are 00 idle, 01 start, 10 resume and 11 reset.
- R4: The fault flag is set on every entry into idle. A read of address 0 clears both the flag and the pending interrupt.
- R5: `intr` is high while the fault flag is set and mode bit 0 (interrupt mask) is low. The reset-complete interrupt is raised even when the mask is set.
- R6: A start or resume issued when the chain pointer is zero stays idle with fault code 4'h1. A resume issued when the last stop was not resumable stays idle with code 4'hC.
- R7: An idle command issued while running has its effect only at the next parameter-block completion, giving code 4'h4. A reset command issued while running aborts at once.
- R8: Each result block written decrements the result count. A decrement that reaches zero aborts the run with code 4'h2. A start value of zero wraps to FFFF and does not abort.
- R9: Writes to both pointers and to the count are ignored unless the controller is idle. The mode word may be written in any state except initialisation.
- R10: A command written at address 0 is accepted exactly `CMD_LAT` clocks later (default 4). Until then the command field and the state keep their old values.
- R11: `ready` is low during any host access made while initialising.
- R12: While running, the block returns to idle on the following strobes. A timeout of kind k gives code {2'b10,k} and is resumable. An error stop gives 4'h5 and a wait stop gives 4'h3, both resumable. End of chain gives 4'h0 and is not resumable. Each of these takes effect on the clock edge that samples the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Register select, active low |
| addr | input | 3 | Register word address |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| wdata | input | 16 | Host write data |
| rdata | output | 16 | Host read data |
| ready | output | 1 | Low to stall a host access |
| intr | output | 1 | Interrupt request |
| chain_run | output | 1 | Engine may execute the chain |
| chain_resumed | output | 1 | Current run is a resume |
| eng_iopb_done | input | 1 | Engine finished a parameter block |
| eng_chain_end | input | 1 | That block was the last in the chain |
| eng_err_stop | input | 1 | That block ended with a fatal error and stop-on-error |
| eng_wait_stop | input | 1 | That block carried the wait option |
| eng_srb_wr | input | 1 | Engine wrote one result block |
| eng_tmo | input | 1 | Memory timeout |
| eng_tmo_kind | input | 2 | Timeout kind: 0 block fetch, 1 map, 2 data, 3 result write |

## Verification
Host commands show their effect `CMD_LAT` edges after the write edge. The bench therefore reads the status once right after the write, to confirm nothing has moved, and again after eight cycles. Engine strobes are held for one edge, and the resulting idle state and fault code are read on the following cycle. Register reads are combinational, so `rdata` is sampled within the access cycle, before the edge that applies the read-clear. Initialisation lasts `RST_CYC` edges, so `ready` is probed inside that window and the reset-complete status after it.

// File: rtl/dkc_pkg.sv
package dkc_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned PTR_W  = 32;

  typedef enum logic [1:0] {
    CMD_IDLE   = 2'b00,
    CMD_START  = 2'b01,
    CMD_RESUME = 2'b10,
    CMD_RESET  = 2'b11
  } cmd_e;

  typedef enum logic [1:0] {
    ST_RST,
    ST_IDLE,
    ST_RUN,
    ST_RERUN
  } st_e;

  typedef enum logic [3:0] {
    FT_NORMAL     = 4'h0,
    FT_NULLPTR    = 4'h1,
    FT_AREA_FULL  = 4'h2,
    FT_WAIT       = 4'h3,
    FT_FORCED     = 4'h4,
    FT_ERR_STOP   = 4'h5,
    FT_IOPB_TMO   = 4'h8,
    FT_MAP_TMO    = 4'h9,
    FT_DATA_TMO   = 4'hA,
    FT_SRB_TMO    = 4'hB,
    FT_BAD_RESUME = 4'hC,
    FT_RST_DONE   = 4'hF
  } fault_e;

  localparam logic [2:0] ADR_CS     = 3'd0;
  localparam logic [2:0] ADR_MODE   = 3'd1;
  localparam logic [2:0] ADR_NBP_LO = 3'd2;
  localparam logic [2:0] ADR_NBP_HI = 3'd3;
  localparam logic [2:0] ADR_SRP_LO = 3'd4;
  localparam logic [2:0] ADR_SRP_HI = 3'd5;
  localparam logic [2:0] ADR_SRL    = 3'd6;
endpackage

// File: rtl/dkc_cmd_sync.sv
module dkc_cmd_sync #(
  parameter int unsigned CMD_LAT = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       flush,
  input  logic       wr_stb,
  input  logic [1:0] wr_cmd,
  output logic       fire,
  output logic [1:0] fire_cmd
);
  localparam int unsigned CW = $clog2(CMD_LAT + 1);

  logic          pend_q, pend_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [1:0]    cmd_q, cmd_d;

  assign fire     = pend_q && (cnt_q == CW'(CMD_LAT - 1));
  assign fire_cmd = cmd_q;

  always_comb begin
    pend_d = pend_q;
    cnt_d  = cnt_q;
    cmd_d  = cmd_q;
    if (flush) begin
      pend_d = 1'b0;
      cnt_d  = '0;
    end else if (wr_stb) begin
      pend_d = 1'b1;
      cnt_d  = '0;
      cmd_d  = wr_cmd;
    end else if (fire) begin
      pend_d = 1'b0;
    end else if (pend_q) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
      cmd_q  <= 2'b00;
    end else begin
      pend_q <= pend_d;
      cnt_q  <= cnt_d;
      cmd_q  <= cmd_d;
    end
  end

  AST_CMD_NOT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !flush && (CMD_LAT > 1)) |=> !fire); // R10
endmodule

// File: rtl/dkc_regs.sv
module dkc_regs
  import dkc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_rst,
  input  logic              idle,
  input  logic              acc,
  input  logic              host_wr,
  input  logic [2:0]        addr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              srb_dec,
  input  logic [WORD_W-1:0] status_word,
  output logic [WORD_W-1:0] mode,
  output logic              nbp_zero,
  output logic              srl_one,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] mode_q, mode_d;
  logic [PTR_W-1:0]  nbp_q, nbp_d;
  logic [PTR_W-1:0]  srp_q, srp_d;
  logic [WORD_W-1:0] srl_q, srl_d;
  logic              wr_locked;

  assign wr_locked = host_wr && idle;

  always_comb begin
    mode_d = mode_q;
    nbp_d  = nbp_q;
    srp_d  = srp_q;
    srl_d  = srl_q;
    if (in_rst) begin
      mode_d = '0;
    end else if (host_wr && addr == ADR_MODE) begin
      mode_d = wdata;
    end
    if (wr_locked) begin
      case (addr)
        ADR_NBP_LO: nbp_d[WORD_W-1:0]      = wdata;
        ADR_NBP_HI: nbp_d[PTR_W-1:WORD_W]  = wdata;
        ADR_SRP_LO: srp_d[WORD_W-1:0]      = wdata;
        ADR_SRP_HI: srp_d[PTR_W-1:WORD_W]  = wdata;
        ADR_SRL:    srl_d                  = wdata;
        default: ;
      endcase
    end else if (srb_dec) begin
      srl_d = srl_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      nbp_q  <= '0;
      srp_q  <= '0;
      srl_q  <= '0;
    end else begin
      mode_q <= mode_d;
      nbp_q  <= nbp_d;
      srp_q  <= srp_d;
      srl_q  <= srl_d;
    end
  end

  assign mode     = mode_q;
  assign nbp_zero = (nbp_q == '0);
  assign srl_one  = (srl_q == WORD_W'(1));

  always_comb begin
    rdata = '0;
    if (acc) begin
      case (addr)
        ADR_CS:     rdata = status_word;
        ADR_MODE:   rdata = mode_q;
        ADR_NBP_LO: rdata = nbp_q[WORD_W-1:0];
        ADR_NBP_HI: rdata = nbp_q[PTR_W-1:WORD_W];
        ADR_SRP_LO: rdata = srp_q[WORD_W-1:0];
        ADR_SRP_HI: rdata = srp_q[PTR_W-1:WORD_W];
        ADR_SRL:    rdata = srl_q;
        default:    rdata = '0;
      endcase
    end
  end

  AST_PTRS_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |=> ($stable(nbp_q) && $stable(srp_q))); // R9
  AST_MODE_CLEARED_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    in_rst |=> (mode_q == '0)); // R2
endmodule

// File: rtl/dkc_seq.sv
module dkc_seq
  import dkc_pkg::*;
#(
  parameter int unsigned RST_CYC = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fire,
  input  logic [1:0] fire_cmd,
  input  logic       nbp_zero,
  input  logic       srl_one,
  input  logic       status_rd,
  input  logic       eng_iopb_done,
  input  logic       eng_chain_end,
  input  logic       eng_err_stop,
  input  logic       eng_wait_stop,
  input  logic       eng_srb_wr,
  input  logic       eng_tmo,
  input  logic [1:0] eng_tmo_kind,
  output st_e        st,
  output logic       cf,
  output logic [3:0] cft,
  output logic [1:0] cmd_fld,
  output logic       rst_irq
);
  localparam int unsigned RCW = $clog2(RST_CYC + 1);

  st_e            st_q, st_d;
  logic [RCW-1:0] rcnt_q, rcnt_d;
  logic           cf_q, cf_d;
  fault_e         cft_q, cft_d;
  logic [1:0]     cmd_q, cmd_d;
  logic           resum_q, resum_d;
  logic           stop_q, stop_d;
  logic           rirq_q, rirq_d;
  logic           idle_evt, idle_res, busy;
  fault_e         idle_code;

  assign busy = (st_q == ST_RUN) || (st_q == ST_RERUN);

  always_comb begin
    st_d      = st_q;
    rcnt_d    = rcnt_q;
    cf_d      = cf_q;
    cft_d     = cft_q;
    cmd_d     = cmd_q;
    resum_d   = resum_q;
    stop_d    = stop_q;
    rirq_d    = rirq_q;
    idle_evt  = 1'b0;
    idle_res  = resum_q;
    idle_code = FT_NORMAL;
    if (status_rd) begin
      cf_d   = 1'b0;
      rirq_d = 1'b0;
    end
    if (fire) cmd_d = fire_cmd;
    unique case (st_q)
      ST_RST: begin
        cmd_d   = CMD_IDLE;
        cf_d    = 1'b0;
        cft_d   = FT_NORMAL;
        resum_d = 1'b0;
        stop_d  = 1'b0;
        rirq_d  = 1'b0;
        if (rcnt_q == RCW'(RST_CYC - 1)) begin
          st_d   = ST_IDLE;
          cf_d   = 1'b1;
          cft_d  = FT_RST_DONE;
          rirq_d = 1'b1;
        end else begin
          rcnt_d = rcnt_q + 1'b1;
        end
      end
      ST_IDLE: begin
        if (fire) begin
          case (fire_cmd)
            CMD_START: begin
              if (nbp_zero) begin
                idle_evt  = 1'b1;
                idle_code = FT_NULLPTR;
              end else begin
                st_d   = ST_RUN;
                stop_d = 1'b0;
              end
            end
            CMD_RESUME: begin
              if (!resum_q) begin
                idle_evt  = 1'b1;
                idle_code = FT_BAD_RESUME;
              end else if (nbp_zero) begin
                idle_evt  = 1'b1;
                idle_code = FT_NULLPTR;
              end else begin
                st_d   = ST_RERUN;
                stop_d = 1'b0;
              end
            end
            CMD_RESET: begin
              st_d   = ST_RST;
              rcnt_d = '0;
            end
            default: ;
          endcase
        end
      end
      ST_RUN, ST_RERUN: begin
        if (fire && fire_cmd == CMD_RESET) begin
          st_d   = ST_RST;
          rcnt_d = '0;
        end else if (eng_tmo) begin
          idle_evt  = 1'b1;
          idle_code = fault_e'({2'b10, eng_tmo_kind});
          idle_res  = 1'b1;
        end else if (eng_srb_wr && srl_one) begin
          idle_evt  = 1'b1;
          idle_code = FT_AREA_FULL;
          idle_res  = 1'b1;
        end else if (eng_iopb_done) begin
          if (eng_err_stop) begin
            idle_evt  = 1'b1;
            idle_code = FT_ERR_STOP;
            idle_res  = 1'b1;
          end else if (eng_wait_stop) begin
            idle_evt  = 1'b1;
            idle_code = FT_WAIT;
            idle_res  = 1'b1;
          end else if (eng_chain_end) begin
            idle_evt  = 1'b1;
            idle_code = FT_NORMAL;
            idle_res  = 1'b0;
          end else if (stop_q || (fire && fire_cmd == CMD_IDLE)) begin
            idle_evt  = 1'b1;
            idle_code = FT_FORCED;
            idle_res  = 1'b1;
          end
        end else if (fire && fire_cmd == CMD_IDLE) begin
          stop_d = 1'b1;
        end
      end
      default: st_d = ST_RST;
    endcase
    if (idle_evt) begin
      st_d    = ST_IDLE;
      cf_d    = 1'b1;
      cft_d   = idle_code;
      resum_d = idle_res;
      stop_d  = 1'b0;
      rirq_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_RST;
      rcnt_q  <= '0;
      cf_q    <= 1'b0;
      cft_q   <= FT_NORMAL;
      cmd_q   <= 2'b00;
      resum_q <= 1'b0;
      stop_q  <= 1'b0;
      rirq_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      rcnt_q  <= rcnt_d;
      cf_q    <= cf_d;
      cft_q   <= cft_d;
      cmd_q   <= cmd_d;
      resum_q <= resum_d;
      stop_q  <= stop_d;
      rirq_q  <= rirq_d;
    end
  end

  assign st      = st_q;
  assign cf      = cf_q;
  assign cft     = cft_q;
  assign cmd_fld = cmd_q;
  assign rst_irq = rirq_q;

  AST_IDLE_ENTRY_SETS_CF: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE) ##1 (st_q == ST_IDLE) |-> cf_q); // R4
  AST_NULL_START_REJECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && fire && fire_cmd == CMD_START && nbp_zero)
      |=> (st_q == ST_IDLE && cft_q == FT_NULLPTR)); // R6
  AST_BAD_RESUME_REJECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && fire && fire_cmd == CMD_RESUME && !resum_q)
      |=> (st_q == ST_IDLE && cft_q == FT_BAD_RESUME)); // R6
  AST_AREA_FULL_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && eng_srb_wr && srl_one && !eng_tmo && !(fire && fire_cmd == CMD_RESET))
      |=> (st_q == ST_IDLE && cft_q == FT_AREA_FULL)); // R8
  AST_IDLE_CMD_DEFERRED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !eng_iopb_done && !eng_tmo && !(eng_srb_wr && srl_one)
      && !(fire && fire_cmd == CMD_RESET))
      |=> (st_q == ST_RUN || st_q == ST_RERUN)); // R7
  AST_RESET_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && fire && fire_cmd == CMD_RESET) |=> (st_q == ST_RST)); // R7
endmodule

// File: rtl/dkc_host_ctrl.sv
module dkc_host_ctrl
  import dkc_pkg::*;
#(
  parameter int unsigned CMD_LAT = 4,
  parameter int unsigned RST_CYC = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs_n,
  input  logic [2:0]  addr,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  output logic        ready,
  output logic        intr,
  output logic        chain_run,
  output logic        chain_resumed,
  input  logic        eng_iopb_done,
  input  logic        eng_chain_end,
  input  logic        eng_err_stop,
  input  logic        eng_wait_stop,
  input  logic        eng_srb_wr,
  input  logic        eng_tmo,
  input  logic [1:0]  eng_tmo_kind
);
  st_e               st;
  logic              cf, rst_irq, fire, nbp_zero, srl_one;
  logic [3:0]        cft;
  logic [1:0]        cmd_fld, fire_cmd;
  logic [WORD_W-1:0] mode, status_word;
  logic              acc, in_rst, idle, host_wr, status_rd, cmd_wr, srb_dec;

  assign acc       = !cs_n;
  assign in_rst    = (st == ST_RST);
  assign idle      = (st == ST_IDLE);
  assign host_wr   = acc && wr_en && !in_rst;
  assign status_rd = acc && rd_en && !in_rst && (addr == ADR_CS);
  assign cmd_wr    = host_wr && (addr == ADR_CS);
  assign chain_run     = (st == ST_RUN) || (st == ST_RERUN);
  assign chain_resumed = (st == ST_RERUN);
  assign srb_dec   = chain_run && eng_srb_wr;
  assign ready     = !(in_rst && acc && (rd_en || wr_en));
  assign intr      = cf && (!mode[0] || rst_irq);
  assign status_word = {cf, chain_run, chain_resumed, 1'b0, cft, 6'b0, cmd_fld};

  dkc_cmd_sync #(.CMD_LAT(CMD_LAT)) u_cmd (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (in_rst),
    .wr_stb   (cmd_wr),
    .wr_cmd   (wdata[1:0]),
    .fire     (fire),
    .fire_cmd (fire_cmd)
  );

  dkc_regs u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_rst      (in_rst),
    .idle        (idle),
    .acc         (acc),
    .host_wr     (host_wr),
    .addr        (addr),
    .wdata       (wdata),
    .srb_dec     (srb_dec),
    .status_word (status_word),
    .mode        (mode),
    .nbp_zero    (nbp_zero),
    .srl_one     (srl_one),
    .rdata       (rdata)
  );

  dkc_seq #(.RST_CYC(RST_CYC)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .fire          (fire),
    .fire_cmd      (fire_cmd),
    .nbp_zero      (nbp_zero),
    .srl_one       (srl_one),
    .status_rd     (status_rd),
    .eng_iopb_done (eng_iopb_done),
    .eng_chain_end (eng_chain_end),
    .eng_err_stop  (eng_err_stop),
    .eng_wait_stop (eng_wait_stop),
    .eng_srb_wr    (eng_srb_wr),
    .eng_tmo       (eng_tmo),
    .eng_tmo_kind  (eng_tmo_kind),
    .st            (st),
    .cf            (cf),
    .cft           (cft),
    .cmd_fld       (cmd_fld),
    .rst_irq       (rst_irq)
  );

  AST_STATUS_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && idle && !fire) |=> (!cf && !intr)); // R4
endmodule

// File: tb/tb_dkc_host_ctrl.sv
module tb_dkc_host_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic [2:0]  addr = 3'd0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [15:0] wdata = 16'h0;
  logic [15:0] rdata;
  logic        ready, intr, chain_run, chain_resumed;
  logic        e_done = 0, e_end = 0, e_err = 0, e_wait = 0, e_srb = 0, e_tmo = 0;
  logic [1:0]  e_kind = 2'b00;
  int          n_chk = 0, n_fail = 0;
  logic        finished = 1'b0;

  always #10 clk = ~clk;

  dkc_host_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .addr(addr), .wr_en(wr_en),
    .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .ready(ready), .intr(intr),
    .chain_run(chain_run), .chain_resumed(chain_resumed),
    .eng_iopb_done(e_done), .eng_chain_end(e_end), .eng_err_stop(e_err),
    .eng_wait_stop(e_wait), .eng_srb_wr(e_srb), .eng_tmo(e_tmo),
    .eng_tmo_kind(e_kind)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  function automatic logic [15:0] sw(input logic c, input logic b, input logic r,
                                     input logic [3:0] t, input logic [1:0] m);
    return {c, b, r, 1'b0, t, 6'b0, m};
  endfunction

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic host_wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    cs_n = 0; wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    cs_n = 1; wr_en = 0;
  endtask

  task automatic host_rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    cs_n = 0; rd_en = 1; addr = a;
    #2 d = rdata;
    @(negedge clk);
    cs_n = 1; rd_en = 0;
  endtask

  task automatic engine(input logic done, input logic cend, input logic err,
                        input logic wt, input logic srb, input logic tmo, input logic [1:0] k);
    @(negedge clk);
    e_done = done; e_end = cend; e_err = err; e_wait = wt; e_srb = srb; e_tmo = tmo; e_kind = k;
    @(negedge clk);
    e_done = 0; e_end = 0; e_err = 0; e_wait = 0; e_srb = 0; e_tmo = 0;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    wait_cyc(3);
    rst_n = 1;
    @(negedge clk);
    cs_n = 0; rd_en = 1; addr = 3'd0;
    #2 check("R11 ready low while initialising", {15'b0, ready}, 16'h0000);
    @(negedge clk);
    cs_n = 1; rd_en = 0;
    wait_cyc(12);
    check("R5 reset-complete interrupt", {15'b0, intr}, 16'h0001);
    host_wr(3'd1, 16'h0001);
    check("R5 reset interrupt ignores mask", {15'b0, intr}, 16'h0001);
    host_rd(3'd0, d);
    check("R2 status after reset", d, sw(1, 0, 0, 4'hF, 2'b00));
    check("R4 interrupt cleared by status read", {15'b0, intr}, 16'h0000);
    host_rd(3'd0, d);
    check("R4 fault flag cleared by read", d, sw(0, 0, 0, 4'hF, 2'b00));
    host_rd(3'd1, d);
    check("R1 mode readback", d, 16'h0001);
    host_wr(3'd1, 16'h0000);
  endtask

  task automatic t_null_and_bad_resume();
    logic [15:0] d;
    host_wr(3'd0, 16'h0001);
    host_rd(3'd0, d);
    check("R10 command not yet accepted", d, sw(0, 0, 0, 4'hF, 2'b00));
    wait_cyc(8);
    check("R4 interrupt on idle entry", {15'b0, intr}, 16'h0001);
    host_rd(3'd0, d);
    check("R6 null pointer start", d, sw(1, 0, 0, 4'h1, 2'b01));
    host_wr(3'd2, 16'h1234);
    host_wr(3'd0, 16'h0002);
    wait_cyc(8);
    host_rd(3'd0, d);
    check("R6 illegal resume", d, sw(1, 0, 0, 4'hC, 2'b10));
  endtask

  task automatic t_regmap();
    logic [15:0] d;
    host_wr(3'd2, 16'h1234); host_wr(3'd3, 16'hABCD);
    host_wr(3'd4, 16'h5678); host_wr(3'd5, 16'h9ABC);
    host_wr(3'd6, 16'h0010);
    host_rd(3'd2, d); check("R1 chain ptr low", d, 16'h1234);
    host_rd(3'd3, d); check("R1 chain ptr high", d, 16'hABCD);
    host_rd(3'd4, d); check("R1 result ptr low", d, 16'h5678);
    host_rd(3'd5, d); check("R1 result ptr high", d, 16'h9ABC);
    host_rd(3'd6, d); check("R1 result count", d, 16'h0010);
    host_rd(3'd7, d); check("R1 reserved reads zero", d, 16'h0000);
    host_wr(3'd0, 16'hFF00);
    wait_cyc(8);
    host_rd(3'd0, d);
    check("R3 status byte read-only", d, sw(0, 0, 0, 4'hC, 2'b00));
  endtask

  task automatic t_mask();
    logic [15:0] d;
    host_wr(3'd1, 16'h0001);
    host_wr(3'd2, 16'h0000); host_wr(3'd3, 16'h0000);
    host_wr(3'd0, 16'h0001);
    wait_cyc(8);
    check("R5 masked interrupt stays low", {15'b0, intr}, 16'h0000);
    host_rd(3'd0, d);
    check("R5 fault flag set though masked", d, sw(1, 0, 0, 4'h1, 2'b01));
    host_wr(3'd1, 16'h0000);
    host_wr(3'd2, 16'h1234); host_wr(3'd3, 16'hABCD);
  endtask

  task automatic t_run_forced();
    logic [15:0] d;
    host_wr(3'd0, 16'h0001);
    check("R10 not running before latency", {15'b0, chain_run}, 16'h0000);
    wait_cyc(8);
    check("R10 running after latency", {15'b0, chain_run}, 16'h0001);
    host_rd(3'd0, d);
    check("R3 busy status", d, sw(0, 1, 0, 4'h1, 2'b01));
    host_wr(3'd2, 16'h1111);
    host_wr(3'd6, 16'h0001);
    host_rd(3'd2, d); check("R9 pointer write ignored while busy", d, 16'h1234);
    host_rd(3'd6, d); check("R9 count write ignored while busy", d, 16'h0010);
    host_wr(3'd1, 16'h0004);
    host_rd(3'd1, d); check("R9 mode writable while busy", d, 16'h0004);
    host_wr(3'd1, 16'h0000);
    host_wr(3'd0, 16'h0000);
    wait_cyc(10);
    check("R7 idle command deferred", {15'b0, chain_run}, 16'h0001);
    engine(1, 0, 0, 0, 0, 0, 2'b00);
    check("R7 stopped after block", {15'b0, chain_run}, 16'h0000);
    host_rd(3'd0, d);
    check("R7 forced idle code", d, sw(1, 0, 0, 4'h4, 2'b00));
  endtask

  task automatic resume_and_check(input string req);
    logic [15:0] d;
    host_wr(3'd0, 16'h0002);
    wait_cyc(8);
    host_rd(3'd0, d);
    check(req, d, sw(0, 1, 1, 4'h4 & 4'h0 | d[11:8], 2'b10));
    check(req, {15'b0, chain_resumed}, 16'h0001);
  endtask

  task automatic t_stops();
    logic [15:0] d;
    resume_and_check("R12 resume after forced idle");
    engine(1, 0, 0, 1, 0, 0, 2'b00);
    host_rd(3'd0, d); check("R12 wait stop", d, sw(1, 0, 0, 4'h3, 2'b10));
    resume_and_check("R12 resume after wait stop");
    engine(0, 0, 0, 0, 0, 1, 2'b01);
    host_rd(3'd0, d); check("R12 map timeout", d, sw(1, 0, 0, 4'h9, 2'b10));
    resume_and_check("R12 resume after timeout");
    engine(1, 0, 1, 0, 0, 0, 2'b00);
    host_rd(3'd0, d); check("R12 error stop", d, sw(1, 0, 0, 4'h5, 2'b10));
    resume_and_check("R12 resume after error stop");
    engine(1, 1, 0, 0, 0, 0, 2'b00);
    host_rd(3'd0, d); check("R12 normal end", d, sw(1, 0, 0, 4'h0, 2'b10));
    host_wr(3'd0, 16'h0002);
    wait_cyc(8);
    host_rd(3'd0, d); check("R12 normal end not resumable", d, sw(1, 0, 0, 4'hC, 2'b10));
  endtask

  task automatic t_area();
    logic [15:0] d;
    host_wr(3'd6, 16'h0002);
    host_wr(3'd0, 16'h0001);
    wait_cyc(8);
    engine(0, 0, 0, 0, 1, 0, 2'b00);
    host_rd(3'd6, d); check("R8 count decremented", d, 16'h0001);
    check("R8 still running", {15'b0, chain_run}, 16'h0001);
    engine(0, 0, 0, 0, 1, 0, 2'b00);
    host_rd(3'd0, d); check("R8 area full abort", d, sw(1, 0, 0, 4'h2, 2'b01));
    host_rd(3'd6, d); check("R8 count at zero", d, 16'h0000);
    host_wr(3'd0, 16'h0001);
    wait_cyc(8);
    engine(0, 0, 0, 0, 1, 0, 2'b00);
    engine(0, 0, 0, 0, 1, 0, 2'b00);
    engine(0, 0, 0, 0, 1, 0, 2'b00);
    host_rd(3'd6, d); check("R8 zero start wraps", d, 16'hFFFD);
    check("R8 no abort on wrap", {15'b0, chain_run}, 16'h0001);
  endtask

  task automatic t_soft_reset();
    logic [15:0] d;
    host_wr(3'd1, 16'h0006);
    host_wr(3'd0, 16'h0003);
    wait_cyc(4);
    check("R7 reset aborts at once", {15'b0, chain_run}, 16'h0000);
    @(negedge clk);
    cs_n = 0; rd_en = 1; addr = 3'd1;
    #2 check("R11 ready low in soft reset", {15'b0, ready}, 16'h0000);
    @(negedge clk);
    cs_n = 1; rd_en = 0;
    wait_cyc(12);
    host_rd(3'd0, d); check("R2 soft reset complete", d, sw(1, 0, 0, 4'hF, 2'b00));
    host_rd(3'd1, d); check("R2 mode cleared", d, 16'h0000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_null_and_bad_resume();
    t_regmap();
    t_mask();
    t_run_forced();
    t_stops();
    t_area();
    t_soft_reset();
    wait_cyc(2);
    finish_run();
  end
endmodule